// File: doc/BRIEF.md
# Video Output Bus Formatter

This block sits at the end of a video receive pipeline. It takes one processed pixel per strobe, given as three components with horizontal sync, vertical sync, data-enable and a field flag, and places it on a parallel output bus three lanes wide. A format code selects the layout. The layouts are full or reduced-depth 4:4:4, a two-lane 4:2:2 bus, a single-lane 4:2:2 word stream that carries its timing as embedded codes, and a dual-edge layout that sends each pixel as two half-width words. The output stage can route any source lane to any output lane and can reverse the bit order of every lane.

Upstream logic has already converted, resampled and dithered the pixels. In 4:2:2 formats the chroma on the low input component already alternates between Cb and Cr. In the single-lane and dual-edge formats the upstream logic strobes a new pixel every second clock, and the block emits one word in each of the two cycles. In every other format it strobes a pixel on every clock. All configuration inputs are shadowed and take effect only when vertical sync rises, so a frame is never split across two layouts.

Top module: `vof_bus_formatter`

## Requirements
- R1: In the 30-bit 4:4:4 format (code 0) the bus carries B/Cb on bits 9:0, G/Y on bits 19:10 and R/Cr on bits 29:20. From the cycle after a strobe, the outputs show the pixel that was accepted two strobes before that most recent one.
- R2: In the narrow formats (codes 1, 3, 5 and 7) each 10-bit lane carries its 8-bit value in bits 9:2, and bits 1:0 of every lane are driven to 0.
- R3: In 4:2:2 two-lane formats (code 2 for 20-bit, code 3 for 16-bit), Y is on the middle lane, chroma is on the low lane and the high lane is 0.
- R4: In embedded-code formats (code 4 for 10-bit, code 5 for 8-bit), each pixel gives two words on the middle lane, chroma and then Y. Only one lane is non-zero. out_first is high in the cycle after a strobe and low otherwise.
- R5: In embedded-code formats, the two blanking pixels just before active video carry FF,00,00,XY with H=0, and the two just after it carry FF,00,00,XY with H=1. XY is {1,F,V,H,V^H,F^H,F^V,F^V^H}, with F and V taken from the field input and vsync of the current pixel, and it is scaled by 4 on the 10-bit lane. FF is a 10-bit word of all ones. At least four blanking pixels separate active runs. out_hs, out_vs and out_de are 0 in these formats.
- R6: In dual-edge formats (code 6 for 30-bit, code 7 for 24-bit), the first word of a pixel holds bus bits 14:0 of its mapped 4:4:4 layout and the second word holds bits 29:15. Both halves go out on bits 14:0, and bits 29:15 are 0.
- R7: Output lane i, for i = 0, 1, 2, takes source lane cfg_lane_sel[2i+1:2i]. The value 3 gives 0, and identity is 6'b100100.
- R8: When cfg_rev is set, each lane is bit-reversed over its significant bits: bits 9:0 in wide formats and bits 9:2 in narrow ones.
- R9: While data-enable is low, RGB 4:4:4 outputs 0 on all lanes. YCbCr outputs Y=64 and C=512 on the 10-bit scale, and that includes the single-lane words, where chroma comes first and Y second.
- R10: Format, colour space, lane select and reversal are sampled only at a strobe whose vsync is high after the previous strobe's was low. After reset the block uses code 0, RGB, identity mapping with no reversal, and all outputs are 0.
- R11: In separate-sync formats, out_hs, out_vs and out_de belong to the same pixel as the data on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_stb | input | 1 | A new pixel is present on the inputs |
| comp_lo | input | 10 | B or Cb (4:4:4), chroma (4:2:2) |
| comp_mid | input | 10 | G or Y |
| comp_hi | input | 10 | R or Cr (4:4:4 only) |
| in_hs | input | 1 | Horizontal sync of the pixel |
| in_vs | input | 1 | Vertical sync of the pixel |
| in_de | input | 1 | Active-video flag of the pixel |
| in_field | input | 1 | Field flag of the pixel |
| cfg_fmt | input | 3 | Bus format code |
| cfg_ycc | input | 1 | 4:4:4 data is YCbCr (selects blanking levels) |
| cfg_lane_sel | input | 6 | Source lane for each output lane |
| cfg_rev | input | 1 | Reverse bit order within lanes |
| vid_bus | output | 30 | Output data bus |
| out_hs | output | 1 | Horizontal sync aligned to the bus |
| out_vs | output | 1 | Vertical sync aligned to the bus |
| out_de | output | 1 | Data-enable aligned to the bus |
| out_first | output | 1 | First word of a pixel slot |

## Verification
The bench builds the block with its default component width of 10 bits, so the lanes split the bus at bits 10 and 20. This makes the narrow 8-bit layouts differ from the wide ones only in their two low bits per lane, and makes the dual-edge halves exactly 15 bits. The bench keeps its own model of pixel history and shadowed configuration. It compares every output on every clock across all eight format codes, several lane maps including a zeroed lane, bit reversal in wide and narrow formats, both field values in the code words, and a mid-frame configuration write that must not take effect.

// File: rtl/vofmt_pkg.sv
// Package: shared types for the video output bus formatter.
// Holds the format code, the shadowed configuration record and the
// small decode helpers that several modules use.
package vofmt_pkg;

    typedef enum logic [2:0] {
        FMT_444_30 = 3'd0,
        FMT_444_24 = 3'd1,
        FMT_422_20 = 3'd2,
        FMT_422_16 = 3'd3,
        FMT_EMB_10 = 3'd4,
        FMT_EMB_8  = 3'd5,
        FMT_DDR_30 = 3'd6,
        FMT_DDR_24 = 3'd7
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic       ycc;
        logic [5:0] lane_sel;
        logic       rev;
    } fmt_cfg_t;

    localparam fmt_cfg_t CFG_RESET = '{fmt: FMT_444_30, ycc: 1'b0,
                                       lane_sel: 6'b10_01_00, rev: 1'b0};

    // Odd codes keep only eight significant bits per lane.
    function automatic logic fmt_narrow(fmt_e f);
        logic [2:0] v;
        v = f;
        return v[0];
    endfunction

    function automatic logic fmt_emb(fmt_e f);
        return (f == FMT_EMB_10) || (f == FMT_EMB_8);
    endfunction

    function automatic logic fmt_ddr(fmt_e f);
        return (f == FMT_DDR_30) || (f == FMT_DDR_24);
    endfunction

endpackage

// File: rtl/vof_cfg_shadow.sv
// Configuration shadow.
// Holds the active configuration and loads the pending one only on a
// strobe whose vsync is high after the previous strobe's was low.
// Assumes vsync is a level carried with each strobed pixel.
module vof_cfg_shadow
    import vofmt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pix_stb,
    input  logic     in_vs,
    input  fmt_cfg_t cfg_next,
    output fmt_cfg_t cfg_act
);

    logic vs_seen;

    // Track vsync per pixel and load the shadow on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_seen <= 1'b0;
            cfg_act <= CFG_RESET;
        end else if (pix_stb) begin
            vs_seen <= in_vs;
            if (in_vs && !vs_seen) begin
                cfg_act <= cfg_next;
            end
        end
    end

endmodule

// File: rtl/vof_pix_hist.sv
// Pixel history window.
// Shifts every strobed pixel through a window of 2*LOOK+1 stages. The
// middle stage is the pixel on the bus; the data-enable of every stage
// is exported so the code inserter can see LOOK pixels on each side.
// Assumes the pixel record carries data-enable at bit 3*COMP_W+2.
module vof_pix_hist #(
    parameter int COMP_W = 10,
    parameter int LOOK   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pix_stb,
    input  logic [3*COMP_W+3:0]   pix_in,
    output logic [3*COMP_W+3:0]   cur_pix,
    output logic [2*LOOK:0]       de_win,
    output logic                  first
);

    localparam int PIX_W = 3 * COMP_W + 4;
    localparam int DEPTH = 2 * LOOK + 1;
    localparam int DE_B  = 3 * COMP_W + 2;

    logic [PIX_W-1:0] stg_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            // Load the newest pixel on each strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)       stg_q[g] <= '0;
                else if (pix_stb) stg_q[g] <= pix_in;
            end
        end else begin : g_tail
            // Age the pixel one slot on each strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)       stg_q[g] <= '0;
                else if (pix_stb) stg_q[g] <= stg_q[g-1];
            end
        end
        assign de_win[g] = stg_q[g][DE_B];
    end

    // Mark the cycle right after a strobe as the first word of a slot.
    always_ff @(posedge clk) begin
        if (!rst_n) first <= 1'b0;
        else        first <= pix_stb;
    end

    assign cur_pix = stg_q[LOOK];

endmodule

// File: rtl/vof_word_build.sv
// Lane builder.
// Places the current pixel, blanking levels or embedded timing codes
// on three raw lanes according to the format code. Lane mapping,
// reversal and narrowing happen afterwards.
// Assumes WIN = 5 (two pixels of look-ahead and look-back, because a
// four-word code spans two two-word pixel slots) and COMP_W >= 10.
module vof_word_build
    import vofmt_pkg::*;
#(
    parameter int COMP_W = 10,
    parameter int WIN    = 5
) (
    input  fmt_e                  fmt,
    input  logic                  ycc,
    input  logic [COMP_W-1:0]     c_lo,
    input  logic [COMP_W-1:0]     c_mid,
    input  logic [COMP_W-1:0]     c_hi,
    input  logic                  cur_vs,
    input  logic                  cur_field,
    input  logic [WIN-1:0]        de_win,
    input  logic                  first,
    output logic [3*COMP_W-1:0]   lanes
);

    localparam int CUR = WIN / 2;
    localparam int PAD = COMP_W - 8;
    localparam logic [COMP_W-1:0] BLANK_Y = COMP_W'(1) << (COMP_W - 4);
    localparam logic [COMP_W-1:0] BLANK_C = COMP_W'(1) << (COMP_W - 1);
    localparam logic [COMP_W-1:0] ONES    = '1;

    // Build the protected status word, scaled to the lane width.
    function automatic logic [COMP_W-1:0] xy_word(logic f, logic v, logic h);
        logic [7:0] b;
        b = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
        return {b, {PAD{1'b0}}};
    endfunction

    logic [COMP_W-1:0] emb_w;

    // Choose the single-lane word: data, a code word or blanking.
    always_comb begin
        if (de_win[CUR])        emb_w = first ? c_lo : c_mid;
        else if (de_win[CUR-1]) emb_w = first ? '0 : xy_word(cur_field, cur_vs, 1'b0);
        else if (de_win[CUR-2]) emb_w = first ? ONES : '0;
        else if (de_win[CUR+1]) emb_w = first ? ONES : '0;
        else if (de_win[CUR+2]) emb_w = first ? '0 : xy_word(cur_field, cur_vs, 1'b1);
        else                    emb_w = first ? BLANK_C : BLANK_Y;
    end

    // Assemble the three raw lanes for the selected layout.
    always_comb begin
        case (fmt)
            FMT_422_20, FMT_422_16: begin
                lanes = de_win[CUR] ? {{COMP_W{1'b0}}, c_mid, c_lo}
                                    : {{COMP_W{1'b0}}, BLANK_Y, BLANK_C};
            end
            FMT_EMB_10, FMT_EMB_8: begin
                lanes = {{COMP_W{1'b0}}, emb_w, {COMP_W{1'b0}}};
            end
            default: begin
                if (de_win[CUR]) lanes = {c_hi, c_mid, c_lo};
                else if (ycc)    lanes = {BLANK_C, BLANK_Y, BLANK_C};
                else             lanes = '0;
            end
        endcase
    end

endmodule

// File: rtl/vof_lane_map.sv
// Lane mapper.
// Routes a chosen source lane to each output lane (the select value
// LANES or above gives zero), optionally reverses the bit order over
// the significant bits, and clears the padding bits in narrow formats.
module vof_lane_map #(
    parameter int COMP_W = 10,
    parameter int LANES  = 3,
    parameter int SEL_W  = 2
) (
    input  logic [LANES*COMP_W-1:0] raw,
    input  logic [LANES*SEL_W-1:0]  lane_sel,
    input  logic                    rev,
    input  logic                    narrow,
    output logic [LANES*COMP_W-1:0] mapped
);

    localparam int NARROW_W = 8;
    localparam int PAD      = COMP_W - NARROW_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SEL_W-1:0]  sel;
        logic [COMP_W-1:0] src;
        logic [COMP_W-1:0] flip;

        assign sel = lane_sel[i*SEL_W +: SEL_W];

        // Pick the source lane for this output lane.
        always_comb begin
            src = '0;
            for (int s = 0; s < LANES; s++) begin
                if (int'(sel) == s) src = raw[s*COMP_W +: COMP_W];
            end
        end

        // Reverse over the significant bits, then clear the padding.
        always_comb begin
            flip = src;
            if (rev) begin
                flip = '0;
                if (narrow) begin
                    for (int b = 0; b < NARROW_W; b++) flip[COMP_W-1-b] = src[PAD+b];
                end else begin
                    for (int b = 0; b < COMP_W; b++) flip[COMP_W-1-b] = src[b];
                end
            end
            if (narrow) flip[PAD-1:0] = '0;
        end

        assign mapped[i*COMP_W +: COMP_W] = flip;
    end

endmodule

// File: rtl/vof_bus_formatter.sv
// Video output bus formatter, top level.
// Shadows the configuration at frame start, keeps a short pixel history
// for code insertion, builds and maps the lanes, and splits each pixel
// into halves for the dual-edge formats. Assumes the pixel strobe comes
// every second clock in embedded-code and dual-edge formats and every
// clock otherwise; COMP_W is even and at least 10.
module vof_bus_formatter
    import vofmt_pkg::*;
#(
    parameter int COMP_W     = 10,
    parameter int LANE_SEL_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_stb,
    input  logic [COMP_W-1:0]       comp_lo,
    input  logic [COMP_W-1:0]       comp_mid,
    input  logic [COMP_W-1:0]       comp_hi,
    input  logic                    in_hs,
    input  logic                    in_vs,
    input  logic                    in_de,
    input  logic                    in_field,
    input  logic [2:0]              cfg_fmt,
    input  logic                    cfg_ycc,
    input  logic [3*LANE_SEL_W-1:0] cfg_lane_sel,
    input  logic                    cfg_rev,
    output logic [3*COMP_W-1:0]     vid_bus,
    output logic                    out_hs,
    output logic                    out_vs,
    output logic                    out_de,
    output logic                    out_first
);

    localparam int NUM_LANES = 3;
    localparam int BUS_W     = NUM_LANES * COMP_W;
    localparam int HALF_W    = BUS_W / 2;
    localparam int LOOK      = 2;
    localparam int WIN       = 2 * LOOK + 1;
    localparam int PIX_W     = BUS_W + 4;

    fmt_cfg_t            cfg_next;
    fmt_cfg_t            cfg_act;
    logic [PIX_W-1:0]    pix_in;
    logic [PIX_W-1:0]    cur_pix;
    logic [WIN-1:0]      de_win;
    logic                first;
    logic [BUS_W-1:0]    raw_lanes;
    logic [BUS_W-1:0]    full_bus;
    logic                emb_mode;

    assign cfg_next = '{fmt: fmt_e'(cfg_fmt), ycc: cfg_ycc,
                        lane_sel: cfg_lane_sel, rev: cfg_rev};
    assign pix_in   = {in_field, in_de, in_vs, in_hs, comp_hi, comp_mid, comp_lo};

    vof_cfg_shadow u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_stb  (pix_stb),
        .in_vs    (in_vs),
        .cfg_next (cfg_next),
        .cfg_act  (cfg_act)
    );

    vof_pix_hist #(.COMP_W(COMP_W), .LOOK(LOOK)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_stb (pix_stb),
        .pix_in  (pix_in),
        .cur_pix (cur_pix),
        .de_win  (de_win),
        .first   (first)
    );

    vof_word_build #(.COMP_W(COMP_W), .WIN(WIN)) u_build (
        .fmt       (cfg_act.fmt),
        .ycc       (cfg_act.ycc),
        .c_lo      (cur_pix[0 +: COMP_W]),
        .c_mid     (cur_pix[COMP_W +: COMP_W]),
        .c_hi      (cur_pix[2*COMP_W +: COMP_W]),
        .cur_vs    (cur_pix[BUS_W+1]),
        .cur_field (cur_pix[BUS_W+3]),
        .de_win    (de_win),
        .first     (first),
        .lanes     (raw_lanes)
    );

    vof_lane_map #(.COMP_W(COMP_W), .LANES(NUM_LANES), .SEL_W(LANE_SEL_W)) u_map (
        .raw      (raw_lanes),
        .lane_sel (cfg_act.lane_sel),
        .rev      (cfg_act.rev),
        .narrow   (fmt_narrow(cfg_act.fmt)),
        .mapped   (full_bus)
    );

    assign emb_mode = fmt_emb(cfg_act.fmt);

    // Send the lower half first and the upper half second in dual-edge formats.
    always_comb begin
        if (fmt_ddr(cfg_act.fmt)) begin
            vid_bus = first ? {{(BUS_W-HALF_W){1'b0}}, full_bus[HALF_W-1:0]}
                            : {{(BUS_W-HALF_W){1'b0}}, full_bus[BUS_W-1:HALF_W]};
        end else begin
            vid_bus = full_bus;
        end
    end

    // Sync pins follow the bus pixel; codes replace them in embedded formats.
    always_comb begin
        out_hs = emb_mode ? 1'b0 : cur_pix[BUS_W];
        out_vs = emb_mode ? 1'b0 : cur_pix[BUS_W+1];
        out_de = emb_mode ? 1'b0 : cur_pix[BUS_W+2];
    end

    assign out_first = first;

endmodule

// File: rtl/vof_bus_formatter_chk.sv
// Checker for the video output bus formatter: temporal and layout
// properties between the configuration shadow and the output bus.
module vof_bus_formatter_chk
    import vofmt_pkg::*;
#(
    parameter int COMP_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pix_stb,
    input logic                in_vs,
    input fmt_cfg_t            cfg_act,
    input logic [3*COMP_W-1:0] vid_bus,
    input logic                out_first,
    input logic                out_de
);

    localparam int BUS_W  = 3 * COMP_W;
    localparam int HALF_W = BUS_W / 2;
    localparam int PAD    = COMP_W - 8;

    logic       pad_bits;
    logic       has_ff;
    logic [2:0] lane_nz;

    // Gather per-lane facts about the bus.
    always_comb begin
        pad_bits = 1'b0;
        has_ff   = 1'b0;
        for (int i = 0; i < 3; i++) begin
            pad_bits   = pad_bits | (|vid_bus[i*COMP_W +: PAD]);
            has_ff     = has_ff | (&vid_bus[i*COMP_W + PAD +: 8]);
            lane_nz[i] = |vid_bus[i*COMP_W +: COMP_W];
        end
    end

    // R2: narrow single-rate formats never drive the padding bits.
    a_r2_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_act.fmt == FMT_444_24 || cfg_act.fmt == FMT_422_16 || cfg_act.fmt == FMT_EMB_8)
        |-> !pad_bits);

    // R4: embedded formats use a single lane.
    a_r4_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_emb(cfg_act.fmt) |-> $countones(lane_nz) <= 1);

    // R5: a code preamble word only appears as the first word of a slot.
    a_r5_ff_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_emb(cfg_act.fmt) && has_ff) |-> out_first);

    // R6: dual-edge formats leave the upper half of the bus idle.
    a_r6_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_ddr(cfg_act.fmt) |-> vid_bus[BUS_W-1:HALF_W] == '0);

    // R9: RGB 4:4:4 blanking drives all lanes to zero.
    a_r9_rgb_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_de && !cfg_act.ycc && (cfg_act.fmt == FMT_444_30 || cfg_act.fmt == FMT_444_24))
        |-> vid_bus == '0);

    // R10: the shadow only changes after a strobe carrying vsync.
    a_r10_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_act) |-> $past(pix_stb && in_vs));

endmodule

bind vof_bus_formatter vof_bus_formatter_chk #(.COMP_W(COMP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_stb   (pix_stb),
    .in_vs     (in_vs),
    .cfg_act   (cfg_act),
    .vid_bus   (vid_bus),
    .out_first (out_first),
    .out_de    (out_de)
);

// File: tb/test_vof_bus_formatter.sv
// Bench for the video output bus formatter: a behavioural model built
// from a queue of accepted pixels, compared with the outputs every clock.
module test_vof_bus_formatter;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_stb = 1'b0;
    logic [9:0]  comp_lo = '0, comp_mid = '0, comp_hi = '0;
    logic        in_hs = 1'b0, in_vs = 1'b0, in_de = 1'b0, in_field = 1'b0;
    logic [2:0]  cfg_fmt = 3'd0;
    logic        cfg_ycc = 1'b0;
    logic [5:0]  cfg_lane_sel = 6'b100100;
    logic        cfg_rev = 1'b0;
    logic [29:0] vid_bus;
    logic        out_hs, out_vs, out_de, out_first;

    always #(CLK_PERIOD/2) clk = ~clk;

    vof_bus_formatter i_vof_bus_formatter (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb),
        .comp_lo(comp_lo), .comp_mid(comp_mid), .comp_hi(comp_hi),
        .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de), .in_field(in_field),
        .cfg_fmt(cfg_fmt), .cfg_ycc(cfg_ycc), .cfg_lane_sel(cfg_lane_sel),
        .cfg_rev(cfg_rev), .vid_bus(vid_bus), .out_hs(out_hs),
        .out_vs(out_vs), .out_de(out_de), .out_first(out_first)
    );

    typedef struct { int lo; int mid; int hi; bit hs; bit vs; bit de; bit fld; } mpix_t;

    mpix_t hist[$];
    int    m_fmt = 0, m_ycc = 0, m_sel = 6'b100100, m_rev = 0;
    bit    m_vs_prev = 0, m_last_stb = 0, checking = 0, done = 0;
    int    checks = 0, errors = 0;
    string cur_req = "R10";

    function automatic mpix_t hget(int back);
        mpix_t z = '{default: 0};
        if (hist.size() > back) return hist[hist.size()-1-back];
        return z;
    endfunction

    function automatic int rev_bits(int v, bit narrow);
        int r = 0;
        if (narrow) begin
            for (int b = 0; b < 8; b++) if (((v >> (b + 2)) & 1) != 0) r |= 1 << (7 - b);
            return r << 2;
        end
        for (int b = 0; b < CW; b++) if (((v >> b) & 1) != 0) r |= 1 << (CW - 1 - b);
        return r;
    endfunction

    function automatic int xy(bit f, bit v, bit h);
        int b = 128 | (f << 6) | (v << 5) | (h << 4) | ((v ^ h) << 3)
              | ((f ^ h) << 2) | ((f ^ v) << 1) | (f ^ v ^ h);
        return b << 2;
    endfunction

    // Expected {bus, first, hs, vs, de} for the current cycle.
    function automatic logic [33:0] model_out();
        mpix_t p = hget(2);
        bit n1 = hget(1).de, n0 = hget(0).de, q1 = hget(3).de, q2 = hget(4).de;
        bit fst = m_last_stb, narrow = (m_fmt % 2) == 1;
        bit emb = (m_fmt == 4 || m_fmt == 5), ddr = (m_fmt >= 6);
        int l[3], o[3], w;
        logic [29:0] full, bus;
        if (m_fmt == 2 || m_fmt == 3) begin
            l[0] = p.de ? p.lo : 512; l[1] = p.de ? p.mid : 64; l[2] = 0;
        end else if (emb) begin
            if (p.de)    w = fst ? p.lo : p.mid;
            else if (n1) w = fst ? 0 : xy(p.fld, p.vs, 0);
            else if (n0) w = fst ? 1023 : 0;
            else if (q1) w = fst ? 1023 : 0;
            else if (q2) w = fst ? 0 : xy(p.fld, p.vs, 1);
            else         w = fst ? 512 : 64;
            l[0] = 0; l[1] = w; l[2] = 0;
        end else if (p.de) begin
            l[0] = p.lo; l[1] = p.mid; l[2] = p.hi;
        end else if (m_ycc != 0) begin
            l[0] = 512; l[1] = 64; l[2] = 512;
        end else begin
            l[0] = 0; l[1] = 0; l[2] = 0;
        end
        for (int i = 0; i < 3; i++) begin
            int s = (m_sel >> (2 * i)) & 3;
            int v = (s == 3) ? 0 : l[s];
            if (m_rev != 0) v = rev_bits(v, narrow);
            if (narrow) v = v & ~3;
            o[i] = v;
        end
        full = 30'((o[2] << 20) | (o[1] << 10) | o[0]);
        bus  = ddr ? (fst ? {15'b0, full[14:0]} : {15'b0, full[29:15]}) : full;
        return {bus, fst, emb ? 1'b0 : p.hs, emb ? 1'b0 : p.vs, emb ? 1'b0 : p.de};
    endfunction

    // Compare at the falling edge, before new inputs are driven.
    task automatic check_now();
        logic [33:0] exp_v = model_out();
        logic [33:0] got_v = {vid_bus, out_first, out_hs, out_vs, out_de};
        checks++;
        if (got_v !== exp_v) begin
            errors++;
            $display("FAIL %s fmt=%0d: got %h expected %h", cur_req, m_fmt, got_v, exp_v);
        end
    endtask

    task automatic step(bit stb, mpix_t p);
        @(negedge clk);
        if (checking) check_now();
        pix_stb = stb; comp_lo = 10'(p.lo); comp_mid = 10'(p.mid); comp_hi = 10'(p.hi);
        in_hs = p.hs; in_vs = p.vs; in_de = p.de; in_field = p.fld;
        if (stb) begin
            if (p.vs && !m_vs_prev) begin
                m_fmt = int'(cfg_fmt); m_ycc = int'(cfg_ycc);
                m_sel = int'(cfg_lane_sel); m_rev = int'(cfg_rev);
            end
            m_vs_prev = p.vs;
            hist.push_back(p);
            if (hist.size() > 8) void'(hist.pop_front());
        end
        m_last_stb = stb;
    endtask

    task automatic send(bit hs, bit vs, bit de, bit fld);
        mpix_t p;
        p.lo = int'($urandom_range(1019, 4)); p.mid = int'($urandom_range(1019, 4));
        p.hi = int'($urandom_range(1019, 4));
        p.hs = hs; p.vs = vs; p.de = de; p.fld = fld;
        step(1'b1, p);
        if (m_fmt >= 4) step(1'b0, p);
    endtask

    task automatic line(int act, bit fld);
        for (int i = 0; i < 6; i++) send(i < 2, 1'b0, 1'b0, fld);
        for (int i = 0; i < act; i++) send(1'b0, 1'b0, 1'b1, fld);
        for (int i = 0; i < 6; i++) send(1'b0, 1'b0, 1'b0, fld);
    endtask

    task automatic frame(int fmt, bit ycc, int sel, bit rev, bit fld, string req);
        cfg_fmt = 3'(fmt); cfg_ycc = ycc; cfg_lane_sel = 6'(sel); cfg_rev = rev;
        cur_req = req;
        for (int i = 0; i < 4; i++) send(1'b0, 1'b1, 1'b0, fld);
        for (int i = 0; i < 2; i++) send(1'b0, 1'b0, 1'b0, fld);
        line(8, fld);
        line(5, fld);
    endtask

    initial begin
        mpix_t idle = '{default: 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({vid_bus, out_first, out_hs, out_vs, out_de} !== 34'd0) begin
            errors++;
            $display("FAIL R10 reset state: got %h expected 0",
                     {vid_bus, out_first, out_hs, out_vs, out_de});
        end
        checking = 1;
        step(1'b0, idle);
        frame(0, 0, 6'b100100, 0, 0, "R1 R9 R11");
        frame(1, 0, 6'b100100, 0, 0, "R2 R9");
        frame(0, 1, 6'b000110, 1, 0, "R7 R8 R9");
        frame(2, 0, 6'b100100, 0, 0, "R3 R9");
        frame(3, 0, 6'b100100, 1, 0, "R3 R2 R8");
        frame(4, 0, 6'b100100, 0, 0, "R4 R5 R9");
        frame(5, 0, 6'b100100, 0, 1, "R5 R2");
        frame(4, 0, 6'b010010, 1, 1, "R4 R7 R8");
        frame(6, 0, 6'b100100, 0, 0, "R6");
        frame(7, 1, 6'b011000, 1, 0, "R6 R7 R8");
        frame(0, 1, 6'b111001, 0, 0, "R7");
        // Mid-frame write must wait for the next vsync.
        cfg_fmt = 3'd2; cfg_rev = 1'b1; cur_req = "R10";
        line(6, 0);
        frame(2, 0, 6'b100100, 1, 0, "R10 R3");
        step(1'b0, idle);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule